// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter. Every cycle it receives strobes from a few event sources, and each source has eight sub-event lanes. A configuration word chooses one source by its event code and picks lanes of that source with a unit mask. The number of chosen lanes that fire in a cycle is the per-cycle event count. That count then passes through a threshold compare, an optional inversion, an optional rising-edge detector, a privilege filter and a global enable. The result is added to a wide counter.

Software can load the counter at any time. When the counter wraps from all ones to zero it sets a sticky overflow flag. If interrupts are enabled in the configuration, the flag also drives an interrupt line until software clears it. Configuration changes take effect on the cycle after the write.

Top module: `pec_counter`

## Requirements
- R1: After reset, `count_o`, `ovf_o` and `irq_o` are all zero, and the configuration word is zero, so counting is disabled.
- R2: The configuration word has these fields: event code in bits [7:0], unit mask in bits [15:8], threshold in bits [23:16]. Event code CODE_BASE+k selects source k, whose lanes are `lanes_i[k*8+7:k*8]`. Unit-mask bit b enables lane b, and several bits may be combined. The per-cycle count is the number of enabled lanes that are asserted. A code outside CODE_BASE..CODE_BASE+NUM_SRC-1 gives a count of zero.
- R3: With a threshold of zero and edge mode off, the counter adds the whole per-cycle count (0 to 8), and the invert bit (bit 24) has no effect.
- R4: With a nonzero threshold and invert clear, the counter adds one in each cycle whose per-cycle count is greater than or equal to the threshold, and zero otherwise.
- R5: With a nonzero threshold and invert set, the counter adds one in each cycle whose per-cycle count is less than the threshold.
- R6: With edge mode set (bit 25), the counter adds one only in a cycle where the gated condition is true and was false in the previous cycle. The condition is: count nonzero when the threshold is zero, otherwise the R4/R5 compare result. A configuration write clears the remembered previous condition.
- R7: The kernel bit (bit 26) enables counting at privilege level 0. The user bit (bit 27) enables counting at levels 1 to 3. With both bits clear, counting is enabled at every level.
- R8: When the global enable (bit 29) is clear, the counter does not change except by a software write.
- R9: A software write loads `cnt_wdata_i`, which appears on `count_o` in the next cycle. The write takes priority over an increment in the same cycle.
- R10: A wrap past all ones sets the sticky `ovf_o`. `irq_o` equals `ovf_o` AND the interrupt-enable bit (bit 28). `ovf_clr_i` clears the flag, unless a wrap occurs in the same cycle.
- R11: A configuration write is visible from the next cycle. The write cycle itself still counts under the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load configuration word |
| cfg_wdata_i | input | 30 | Configuration word (fields as in R2 to R10) |
| cnt_we_i | input | 1 | Software load of the counter |
| cnt_wdata_i | input | CTR_W | Value to load |
| ovf_clr_i | input | 1 | Clear overflow flag |
| priv_i | input | 2 | Current privilege level |
| lanes_i | input | NUM_SRC*8 | Sub-event strobes of every source |
| count_o | output | CTR_W | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench uses the default build: four sources, a 48-bit counter and event codes starting at 0x10. It sweeps thresholds 0, 1, 2, 3 and 9, both invert settings, both edge settings, all four privilege-bit combinations and all four privilege levels, with a changing event code and unit mask. This includes a code one past the last source. Each configuration is written together with a counter load, and a third of the loads sit two below all ones. As a result, wraps, write-over-increment cycles, counting under the previous configuration in the write cycle, and overflow clears all occur many times across the sweep. A threshold of 9 is above the largest possible per-cycle count, so the compare is constantly false (or constantly true when inverted).

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int LANES = 8;

  typedef struct packed {
    logic       en;
    logic       int_en;
    logic       usr;
    logic       os;
    logic       edge_m;
    logic       inv;
    logic [7:0] cmask;
    logic [7:0] umask;
    logic [7:0] code;
  } pec_cfg_t;

  localparam int CFG_W = $bits(pec_cfg_t);
  localparam int SUM_W = $clog2(LANES + 1);
endpackage

// File: rtl/pec_select.sv
module pec_select
  import pec_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int CODE_BASE = 16
) (
  input  logic [NUM_SRC*LANES-1:0] lanes_i,
  input  logic [7:0]               code_i,
  input  logic [7:0]               umask_i,
  output logic [SUM_W-1:0]         sum_o
);
  logic [7:0]       rel;
  logic             hit;
  logic [LANES-1:0] sel, masked;

  assign rel = code_i - 8'(CODE_BASE);
  assign hit = (code_i >= 8'(CODE_BASE)) && (rel < 8'(NUM_SRC));

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_SRC; k++)
      if (hit && rel == 8'(k)) sel = lanes_i[k*LANES +: LANES];
  end

  assign masked = sel & umask_i;

  always_comb begin
    sum_o = '0;
    for (int b = 0; b < LANES; b++) sum_o = sum_o + SUM_W'(masked[b]);
  end
endmodule

// File: rtl/pec_qualify.sv
module pec_qualify
  import pec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             en_i,
  input  logic             os_i,
  input  logic             usr_i,
  input  logic             edge_i,
  input  logic             inv_i,
  input  logic [7:0]       cmask_i,
  input  logic [1:0]       priv_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [SUM_W-1:0] inc_o
);
  logic ge, cond, priv_ok, gate, live, prev_q;

  assign ge      = {{(8-SUM_W){1'b0}}, sum_i} >= cmask_i;
  assign cond    = (cmask_i == '0) ? (sum_i != '0) : (inv_i ? ~ge : ge);
  assign priv_ok = (!os_i && !usr_i) || ((priv_i == 2'd0) ? os_i : usr_i);
  assign gate    = en_i & priv_ok;
  assign live    = gate & cond;

  // previous qualified condition, dropped on reconfiguration
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       prev_q <= 1'b0;
    else if (cfg_we_i) prev_q <= 1'b0;
    else               prev_q <= live;

  always_comb begin
    if (!gate)                inc_o = '0;
    else if (edge_i)          inc_o = SUM_W'(live & ~prev_q);
    else if (cmask_i == '0)   inc_o = sum_i;
    else                      inc_o = SUM_W'(cond);
  end

  // R6
  edge_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && inc_o != '0 && !cfg_we_i) |=> (inc_o == '0));
  // R4
  thresh_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmask_i != '0) |-> (inc_o <= SUM_W'(1)));
  // R7
  priv_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_i && !usr_i && priv_i != 2'd0) |-> (inc_o == '0));
endmodule

// File: rtl/pec_accum.sv
module pec_accum
  import pec_pkg::*;
#(
  parameter int CTR_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic [SUM_W-1:0] inc_i,
  input  logic             clr_i,
  input  logic             int_en_i,
  output logic [CTR_W-1:0] count_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic [CTR_W:0] nxt;

  assign nxt = {1'b0, count_o} + (CTR_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      count_o <= we_i ? wdata_i : nxt[CTR_W-1:0];
      ovf_o   <= (~we_i & nxt[CTR_W]) | (ovf_o & ~clr_i);
    end

  assign irq_o = ovf_o & int_en_i;

  // R9
  sw_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (count_o == $past(wdata_i)));
  // R10
  wrap_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (count_o < $past(count_o)));
  // R10
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && we_i) |=> !ovf_o);
endmodule

// File: rtl/pec_counter.sv
module pec_counter
  import pec_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int CODE_BASE = 16,
  parameter int CTR_W     = 48
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [CFG_W-1:0]         cfg_wdata_i,
  input  logic                     cnt_we_i,
  input  logic [CTR_W-1:0]         cnt_wdata_i,
  input  logic                     ovf_clr_i,
  input  logic [1:0]               priv_i,
  input  logic [NUM_SRC*LANES-1:0] lanes_i,
  output logic [CTR_W-1:0]         count_o,
  output logic                     ovf_o,
  output logic                     irq_o
);
  pec_cfg_t         cfg_q;
  logic [SUM_W-1:0] sum, inc;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= pec_cfg_t'(cfg_wdata_i);

  pec_select #(.NUM_SRC(NUM_SRC), .CODE_BASE(CODE_BASE)) u_sel (
    .lanes_i (lanes_i),
    .code_i  (cfg_q.code),
    .umask_i (cfg_q.umask),
    .sum_o   (sum)
  );

  pec_qualify u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .en_i     (cfg_q.en),
    .os_i     (cfg_q.os),
    .usr_i    (cfg_q.usr),
    .edge_i   (cfg_q.edge_m),
    .inv_i    (cfg_q.inv),
    .cmask_i  (cfg_q.cmask),
    .priv_i   (priv_i),
    .sum_i    (sum),
    .inc_o    (inc)
  );

  pec_accum #(.CTR_W(CTR_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cnt_we_i),
    .wdata_i  (cnt_wdata_i),
    .inc_i    (inc),
    .clr_i    (ovf_clr_i),
    .int_en_i (cfg_q.int_en),
    .count_o  (count_o),
    .ovf_o    (ovf_o),
    .irq_o    (irq_o)
  );

  // R8
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.en && !cnt_we_i && !cfg_we_i) |=> $stable(count_o));
  // R2
  code_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.code < 8'(CODE_BASE)) |-> (sum == '0));
endmodule

// File: tb/tb_pec_counter.sv
module tb_pec_counter;
  import pec_pkg::*;
  localparam int NUM_SRC = 4, CODE_BASE = 16, CTR_W = 48;
  localparam logic [CTR_W-1:0] MAXV = '1;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic                     cfg_we = 0, cnt_we = 0, ovf_clr = 0;
  logic [CFG_W-1:0]         cfg_wdata = '0;
  logic [CTR_W-1:0]         cnt_wdata = '0;
  logic [1:0]               priv = '0;
  logic [NUM_SRC*LANES-1:0] lanes = '0;
  logic [CTR_W-1:0]         count_o;
  logic                     ovf_o, irq_o;

  pec_counter #(.NUM_SRC(NUM_SRC), .CODE_BASE(CODE_BASE), .CTR_W(CTR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata), .ovf_clr_i(ovf_clr),
    .priv_i(priv), .lanes_i(lanes), .count_o(count_o), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  pec_cfg_t m_cfg = '0;
  logic m_prev = 0, m_ovf = 0;
  logic [63:0] m_cnt = '0;
  logic [31:0] rnd = 32'h1234_5678;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rnd(logic [31:0] x);
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  // one clock: drive at negedge, advance model, check at next negedge
  task automatic step(bit cw, pec_cfg_t ncfg, bit ww, logic [CTR_W-1:0] wv,
                      bit clr, logic [1:0] pv, logic [31:0] lv, string rq);
    int sum, inc, rel;
    bit pok, cond, live;
    logic [63:0] nxt;
    cfg_we = cw; cfg_wdata = ncfg; cnt_we = ww; cnt_wdata = wv;
    ovf_clr = clr; priv = pv; lanes = lv;
    rel = int'(m_cfg.code) - CODE_BASE;
    sum = (rel >= 0 && rel < NUM_SRC) ? $countones(lv[rel*8 +: 8] & m_cfg.umask) : 0;
    pok = (!m_cfg.os && !m_cfg.usr) || ((pv == 0) ? m_cfg.os : m_cfg.usr);
    if (m_cfg.cmask == 0) cond = (sum != 0);
    else cond = m_cfg.inv ? (sum < int'(m_cfg.cmask)) : (sum >= int'(m_cfg.cmask));
    live = m_cfg.en && pok && cond;
    if (!(m_cfg.en && pok)) inc = 0;
    else if (m_cfg.edge_m) inc = (live && !m_prev) ? 1 : 0;
    else if (m_cfg.cmask == 0) inc = sum;
    else inc = cond ? 1 : 0;
    nxt = m_cnt + 64'(inc);
    m_ovf = (!ww && nxt[CTR_W]) || (m_ovf && !clr);
    m_cnt = ww ? 64'(wv) : (nxt & {16'h0, MAXV});
    m_prev = cw ? 1'b0 : live;
    if (cw) m_cfg = ncfg;
    @(negedge clk);
    chk(rq, 64'(count_o), m_cnt);
    chk("R10 ovf", 64'(ovf_o), 64'(m_ovf));
    chk("R10 irq", 64'(irq_o), 64'(m_ovf & m_cfg.int_en));
  endtask

  function automatic string tag_of(pec_cfg_t c, logic [1:0] pv);
    int rel = int'(c.code) - CODE_BASE;
    if (!c.en) return "R8 disabled";
    if ((c.os || c.usr) && !((pv == 0) ? c.os : c.usr)) return "R7 priv";
    if (rel < 0 || rel >= NUM_SRC) return "R2 code miss";
    if (c.edge_m) return "R6 edge";
    if (c.cmask == 0) return "R3 full count";
    return c.inv ? "R5 inverted" : "R4 threshold";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pec_cfg_t c;
    logic [CTR_W-1:0] wv;
    repeat (3) @(negedge clk);
    chk("R1 count", 64'(count_o), 64'd0);
    chk("R1 ovf", 64'(ovf_o), 64'd0);
    chk("R1 irq", 64'(irq_o), 64'd0);
    rst_ni = 1'b1;
    // R8: reset config disables counting even with busy lanes
    for (int i = 0; i < 4; i++) begin
      rnd = next_rnd(rnd);
      step(0, '0, 0, '0, 0, 2'd0, rnd, "R8 reset cfg");
    end
    for (int idx = 0; idx < 320; idx++) begin
      int cmv [5] = '{0, 1, 2, 3, 9};
      c = '0;
      c.cmask  = 8'(cmv[idx % 5]);
      c.inv    = 1'((idx / 5) % 2);
      c.edge_m = 1'((idx / 10) % 2);
      c.os     = 1'((idx / 20) % 2);
      c.usr    = 1'((idx / 40) % 2);
      c.code   = 8'(CODE_BASE + (idx * 3) % 5);
      c.umask  = (idx % 11 == 0) ? 8'hFF : 8'(idx * 73 + 11);
      c.en     = (idx % 13 != 0);
      c.int_en = 1'(idx % 2) ^ 1'((idx / 8) % 2);
      wv = (idx % 3 == 0) ? MAXV - 2 : CTR_W'(idx * 1000);
      rnd = next_rnd(rnd);
      // R9 R11: load and reconfigure together; this cycle counts with old cfg
      step(1, c, 1, wv, (idx % 4 == 0), 2'((idx / 80) % 4), rnd, "R9 R11 write");
      for (int j = 0; j < 12; j++) begin
        rnd = next_rnd(rnd);
        step(0, c, 0, '0, (j == 11 && idx % 5 == 2), 2'((idx / 80) % 4), rnd,
             tag_of(m_cfg, 2'((idx / 80) % 4)));
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule